// File: doc/BRIEF.md
# Bus-Synchronized Clock-Rate Selector

This block turns a single system clock into clock-enable strobes for the bus masters of a subsystem. A 3-bit select field picks the rate for the main processor: every cycle (full speed), or one cycle in 2, 4, 8, 16 or 32. The rate a master runs at sets the length of its bus accesses. An access of N states at a divided rate therefore spans N divided periods. For example, a 4-state access at one-in-four lasts 16 system cycles.

A new select value is not used as soon as it appears. It is taken only on a cycle where the bus reports the end of the current bus cycle, so an access in flight never changes rate partway through. When a different rate is taken, the divider counter restarts from zero. The first strobe at the new rate therefore comes one full divided period later.

Each secondary bus master, such as a transfer controller, has its own speed bit. With the bit clear, that master follows the main processor's divided rate. With the bit set, it runs at full speed. Non-master peripherals always receive a full-rate enable.

There is no data path and no stream interface. All pins are plain control levels or pulses, so there are no valid/ready or back-pressure rules. The block only generates enables: real clock gating and the bus itself are outside it.

Top module: `clk_rate_sel`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) selects full speed and clears the divider. Once the block is in reset, `cpu_ce`, every `sec_ce` bit and `periph_ce` are all 1.
- R2: While the applied select code is 000, `cpu_ce` is 1 in every cycle.
- R3: While the applied code is k, for k from 1 to 5, `cpu_ce` is 1 in exactly one cycle out of every 2^k.
- R4: Codes 110 and 111 behave exactly like code 101, giving one strobe in every 32 cycles.
- R5: A new `speed_sel` value is applied only at a rising edge where `bus_cycle_end` is 1. While `bus_cycle_end` stays 0, the previous rate continues with its phase unchanged, whatever `speed_sel` does.
- R6: Applying a code different from the current one clears the divider. Count the cycle just after the applying edge as cycle 1. The first `cpu_ce` at rate 2^k then falls in cycle 2^k, and every 2^k cycles after that.
- R7: A `bus_cycle_end` pulse while `speed_sel` equals the code already applied does not disturb the phase of `cpu_ce`.
- R8: While `sec_full_speed[i]` is 0, `sec_ce[i]` equals `cpu_ce` in every cycle.
- R9: While `sec_full_speed[i]` is 1, `sec_ce[i]` is 1 in every cycle. The bit acts in the same cycle it changes, without waiting for a bus-cycle end.
- R10: `periph_ce` is 1 in every cycle, whatever the select code and the speed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_sel | input | 3 | Requested rate code: 000 is full speed, k from 1 to 5 is one strobe in 2^k cycles, 110 and 111 act as 101 |
| sec_full_speed | input | NUM_SEC | Per secondary master: 1 gives full speed, 0 follows the processor rate |
| bus_cycle_end | input | 1 | Pulse marking the last cycle of the current bus cycle; the select code is taken at this edge |
| cpu_ce | output | 1 | Clock enable for the main processor |
| sec_ce | output | NUM_SEC | Clock enables for the secondary bus masters |
| periph_ce | output | 1 | Clock enable for non-master peripherals, always 1 |

## Verification
An applied code that is wrong, or one taken without a bus-cycle end, shows on `cpu_ce` as a strobe at the wrong place. It is visible within one period of the intended rate, which is at most 32 cycles. A divider count that is off, or that is not cleared when a rate is applied, moves the first strobe after the switch away from cycle 2^k. That is detectable on the very first period. Mistakes in the routing of the secondary masters show in the same cycle as a mismatch between `sec_ce` and `cpu_ce`, or as a missing full-rate strobe.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;

  // Width of the shift amount that stands for a divide ratio of 2^shift.
  localparam int unsigned SHIFT_W = 3;

  // Turn a select code into a shift. Code 0 is full speed. Codes above
  // the largest ratio saturate at that ratio.
  function automatic logic [SHIFT_W-1:0] sel_to_shift(
    input int unsigned code,
    input int unsigned max_shift
  );
    int unsigned s;
    if (code > max_shift) s = max_shift;
    else                  s = code;
    return SHIFT_W'(s);
  endfunction

endpackage

// File: rtl/crs_rate_latch.sv
module crs_rate_latch #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] speed_sel,
  input  logic             bus_cycle_end,
  output logic [SEL_W-1:0] act_code,
  output logic             restart
);

  logic [SEL_W-1:0] code_q;

  // A different code taken at a bus boundary restarts the divider.
  assign restart  = bus_cycle_end && (speed_sel != code_q);
  assign act_code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (bus_cycle_end) begin
      code_q <= speed_sel;
    end
  end

  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !bus_cycle_end |=> $stable(act_code)) else $error("code moved without boundary"); // R5

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    bus_cycle_end |=> (act_code == $past(speed_sel))) else $error("code not taken"); // R5

endmodule

// File: rtl/crs_divider.sv
module crs_divider #(
  parameter int unsigned MAX_SHIFT = 5,
  parameter int unsigned SHIFT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               ce
);

  localparam int unsigned CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // The count runs from 0 to 2^shift - 1. With shift 0 it stays at 0 and
  // the strobe stays high.
  always_comb begin
    last = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(shift)) last[b] = 1'b1;
    end
  end

  assign ce = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (ce && !restart && shift != '0) |=> !ce) else $error("back-to-back strobe"); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last) else $error("count beyond period"); // R3

  AST_FIRST_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
    ($past(restart) && shift != '0) |-> !ce) else $error("early strobe after switch"); // R6

endmodule

// File: rtl/clk_rate_sel.sv
module clk_rate_sel #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MAX_SHIFT = 5,
  parameter int unsigned NUM_SEC   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   speed_sel,
  input  logic [NUM_SEC-1:0] sec_full_speed,
  input  logic               bus_cycle_end,
  output logic               cpu_ce,
  output logic [NUM_SEC-1:0] sec_ce,
  output logic               periph_ce
);
  import clk_rate_pkg::*;

  logic [SEL_W-1:0]   act_code;
  logic               restart;
  logic [SHIFT_W-1:0] shift;

  crs_rate_latch #(.SEL_W(SEL_W)) u_latch (
    .clk           (clk),
    .rst           (rst),
    .speed_sel     (speed_sel),
    .bus_cycle_end (bus_cycle_end),
    .act_code      (act_code),
    .restart       (restart)
  );

  assign shift = sel_to_shift(int'(act_code), MAX_SHIFT);

  crs_divider #(.MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .shift   (shift),
    .ce      (cpu_ce)
  );

  // Each secondary master either follows the processor rate or runs free.
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    assign sec_ce[g] = sec_full_speed[g] | cpu_ce;
  end

  assign periph_ce = 1'b1;

endmodule

// File: tb/clk_rate_sel_tb.sv
`timescale 1ns/1ps
module clk_rate_sel_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] speed_sel = 3'd0;
  logic [0:0] sec_full_speed = 1'b0;
  logic       bus_cycle_end = 1'b0;
  logic       cpu_ce;
  logic [0:0] sec_ce;
  logic       periph_ce;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state.
  int unsigned cur_code = 0;
  int unsigned cur_div  = 1;
  int unsigned ph       = 0;

  always #10 clk = ~clk;

  clk_rate_sel u_dut (
    .clk            (clk),
    .rst            (rst),
    .speed_sel      (speed_sel),
    .sec_full_speed (sec_full_speed),
    .bus_cycle_end  (bus_cycle_end),
    .cpu_ce         (cpu_ce),
    .sec_ce         (sec_ce),
    .periph_ce      (periph_ce)
  );

  function automatic int unsigned exp_div(input int unsigned code);
    if (code == 0) return 1;
    if (code >= 5) return 32;
    return 1 << code;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample outputs, update the model.
  task automatic cyc(input logic bce_v, input logic [2:0] sel_v, input string tag);
    logic e_cpu;
    @(negedge clk);
    bus_cycle_end = bce_v;
    speed_sel     = sel_v;
    #1;
    ph++;
    e_cpu = ((ph % cur_div) == 0);
    check(tag, cpu_ce, e_cpu);
    check(sec_full_speed[0] ? "R9" : "R8", sec_ce[0], sec_full_speed[0] | e_cpu);
    check("R10", periph_ce, 1'b1);
    if (bce_v && (int'(sel_v) != cur_code)) begin
      cur_code = sel_v;
      cur_div  = exp_div(sel_v);
      ph       = 0;
    end
  endtask

  task automatic run(input int n, input logic [2:0] sel_v, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, sel_v, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; bus_cycle_end = 1'b0;
    @(negedge clk);
    #1;
    check("R1 cpu", cpu_ce, 1'b1);
    check("R1 sec", sec_ce[0], 1'b1);
    check("R1 periph", periph_ce, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    cur_code = 0; cur_div = 1; ph = 0;
  endtask

  task automatic t_full;
    run(12, 3'd0, "R2");
  endtask

  task automatic t_ratios;
    for (int k = 1; k <= 5; k++) begin
      cyc(1'b1, 3'(k), "R3");
      run(exp_div(k), 3'(k), "R6");
      run(2 * exp_div(k), 3'(k), "R3");
    end
  endtask

  task automatic t_unused;
    cyc(1'b1, 3'd6, "R4");
    run(70, 3'd6, "R4");
    cyc(1'b1, 3'd7, "R4");
    run(70, 3'd7, "R4");
  endtask

  task automatic t_deferred;
    cyc(1'b1, 3'd2, "R5");
    run(6, 3'd2, "R5");
    run(21, 3'd5, "R5");
    cyc(1'b1, 3'd5, "R5");
    run(40, 3'd5, "R6");
  endtask

  task automatic t_same_code;
    cyc(1'b1, 3'd3, "R7");
    run(3, 3'd3, "R7");
    cyc(1'b1, 3'd3, "R7");
    run(20, 3'd3, "R7");
  endtask

  task automatic t_secondary;
    sec_full_speed = 1'b0;
    cyc(1'b1, 3'd2, "R8");
    run(16, 3'd2, "R8");
    @(negedge clk);
    sec_full_speed = 1'b1;
    ph++;
    #1;
    check("R9", sec_ce[0], 1'b1);
    run(16, 3'd2, "R9");
    cyc(1'b1, 3'd4, "R9");
    run(20, 3'd4, "R9");
    sec_full_speed = 1'b0;
    run(20, 3'd4, "R8");
  endtask

  task automatic t_reset_mid;
    cyc(1'b1, 3'd5, "R3");
    run(10, 3'd5, "R3");
    t_reset();
    run(8, 3'd0, "R1");
  endtask

  initial begin
    #4_000_000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_ratios();
    t_unused();
    t_deferred();
    t_same_code();
    t_secondary();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule